// File: doc/BRIEF.md
# Timer register bus slave

This block sits between an AHB-Lite bus and the storage of a small timer: a clock divider value, a pending mask, an enable mask, a free-running 64-bit time count and a parameterised set of 64-bit compare values. It turns bus transfers into single-cycle write strobes and returns the current register contents as read data. The registers themselves and the counting and compare logic belong to neighbouring blocks. Those blocks feed their current values in on `*_q` inputs. They latch `wr_data` on the clock edge that closes the cycle in which a strobe is high.

Each register occupies an 8-byte slot, and each 32-bit half of a slot has its own strobe. A 32-bit bus reaches one half per transfer. A 64-bit bus reaches one half or both, depending on the transfer size. A write to either half of compare register n also pulses `pend_clr[n]`, so the pending logic can drop that timer's flag in the same cycle the new compare value lands. The block never stalls and never reports an error. The address space repeats above the register window, because base decoding is done upstream through the select input.

Top module: `tmr_ahb_regif`

## Requirements
- R1: `hreadyout` is 1 and `hresp` is 0 (OKAY) in every cycle, including during reset.
- R2: A transfer is accepted only in a cycle where `hsel`, `hready` and `htrans[1]` are all 1 (NONSEQ 2'b10 or SEQ 2'b11). With `hsel` low, `hready` low, IDLE (2'b00) or BUSY (2'b01), no strobe and no read data follow.
- R3: Address, direction and size are registered at the clock edge that ends the address phase. In the following cycle (the data phase), the strobes are driven with `wr_data` taken from `hwdata` of that same cycle, or read data is driven on `hrdata`. All of these return to zero one cycle later unless another transfer was accepted.
- R4: Slot k covers byte offsets 8k to 8k+7. Slot 0 low half is the prescaler (`presc_we`), slot 1 low half is the pending mask, slot 1 high half is the enable mask (`ien_we`), slot 2 is the time count (`time_we`), and slot 3+n is compare register n (`cmp_we`). Only one register is written per transfer.
- R5: On a 32-bit bus, offset bit 2 picks the half: 0 is the low word (strobe bit 0, read bits 31:0 of the register) and 1 is the high word (strobe bit 1, read bits 63:32). `cmp_we[2n]` and `cmp_we[2n+1]` are the low and high strobes of compare n. Both `wr_data` halves carry `hwdata`.
- R6: On a 64-bit bus, `hsize` 3'b011 accesses both halves of the slot. A smaller size accesses only the half picked by offset bit 2. `wr_data[31:0]` comes from `hwdata[31:0]` and `wr_data[63:32]` from `hwdata[63:32]`. Read data puts the low half on lanes 31:0 and the high half on lanes 63:32, with a lane that is not accessed reading as zero.
- R7: The pending mask is read-only: a write to offset 0x08 produces no strobe.
- R8: A write to either half of compare register n sets `pend_clr[n]` in the same cycle as its `cmp_we` strobe.
- R9: Offsets with no register (such as 0x04, and slots past the last compare register) read as zero and produce no strobe on write. The pending and enable masks read zero-extended to 32 bits.
- R10: The reset input is asynchronous and active low. In any cycle without a read data phase, including the cycles after reset, `hrdata` is zero and no strobe is high.

Ports are listed for the default parameters NCMP=3, AW=32, DW=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| haddr | input | AW | Byte address |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size |
| hwdata | input | DW | Write data (data phase) |
| hready | input | 1 | Bus ready |
| hrdata | output | DW | Read data (data phase) |
| hreadyout | output | 1 | Always 1 |
| hresp | output | 1 | Always 0 |
| presc_q | input | 32 | Current prescaler |
| pend_q | input | NCMP | Current pending mask |
| ien_q | input | NCMP | Current enable mask |
| time_q | input | 64 | Current time count |
| cmp_q | input | 64*NCMP | Compare values, register n at bits 64n+63:64n |
| wr_data | output | 64 | Write value for the neighbour registers |
| presc_we | output | 1 | Prescaler write strobe |
| ien_we | output | 1 | Enable mask write strobe |
| time_we | output | 2 | Time count half strobes {high, low} |
| cmp_we | output | 2*NCMP | Compare half strobes, bit 2n low, 2n+1 high |
| pend_clr | output | NCMP | Pending clear pulse for compare n |

## Verification
Every result of this block is due in exactly one cycle: the data phase that follows the address-phase clock edge. Strobes, `wr_data` and `hrdata` are combinational from the captured phase and the present `hwdata`. The bench therefore drives an address phase, moves the bus to IDLE just after the capturing edge while presenting the write data, and samples at the next falling edge, in the middle of the data phase. It then samples again one cycle later to confirm that the outputs have dropped back to zero. The ready and response outputs are monitored on every falling edge for the whole run.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

  // 8-byte slot numbers; the slot order defines the bus offsets
  localparam int SLOT_PRESC = 0;
  localparam int SLOT_MASKS = 1;
  localparam int SLOT_TIME  = 2;
  localparam int SLOT_CMP0  = 3;

  // byte-offset bits needed to reach the last compare slot
  function automatic int ofs_bits(input int ncmp);
    return $clog2(8 * (SLOT_CMP0 + ncmp));
  endfunction

  localparam logic [1:0] HALF_LO   = 2'b01;
  localparam logic [1:0] HALF_HI   = 2'b10;
  localparam logic [1:0] HALF_BOTH = 2'b11;

endpackage

// File: rtl/tmr_ahb_capture.sv
module tmr_ahb_capture
  import tmr_regif_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer,
  input  logic          hwrite,
  input  logic          dbl,
  input  logic [SW:0]   ofs,
  output logic          acc_vld,
  output logic          acc_wr,
  output logic [SW-1:0] acc_slot,
  output logic [1:0]    acc_half
);

  logic [1:0] half_d;

  always_comb begin
    if (dbl)         half_d = HALF_BOTH;
    else if (ofs[0]) half_d = HALF_HI;
    else             half_d = HALF_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld  <= 1'b0;
      acc_wr   <= 1'b0;
      acc_slot <= '0;
      acc_half <= '0;
    end else begin
      acc_vld <= xfer;
      if (xfer) begin
        acc_wr   <= hwrite;
        acc_slot <= ofs[SW:1];
        acc_half <= half_d;
      end
    end
  end

  // a captured phase always names at least one half
  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> (acc_half != 2'b00));  // R3

endmodule

// File: rtl/tmr_reg_decode.sv
module tmr_reg_decode
  import tmr_regif_pkg::*;
#(
  parameter int NCMP = 3,
  parameter int SW   = 3
) (
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [SW-1:0]     acc_slot,
  input  logic [1:0]        acc_half,
  output logic              presc_we,
  output logic              ien_we,
  output logic [1:0]        time_we,
  output logic [2*NCMP-1:0] cmp_we,
  output logic [NCMP-1:0]   pend_clr
);

  logic wr_go;
  assign wr_go = acc_vld & acc_wr;

  assign presc_we = wr_go & (acc_slot == SW'(SLOT_PRESC)) & acc_half[0];
  // low half of the mask slot is read-only: only the high half strobes
  assign ien_we   = wr_go & (acc_slot == SW'(SLOT_MASKS)) & acc_half[1];
  assign time_we  = (wr_go && acc_slot == SW'(SLOT_TIME)) ? acc_half : 2'b00;

  for (genvar n = 0; n < NCMP; n++) begin : g_cmp
    logic hit;
    assign hit              = wr_go & (acc_slot == SW'(SLOT_CMP0 + n));
    assign cmp_we[2*n +: 2] = hit ? acc_half : 2'b00;
    assign pend_clr[n]      = hit;
  end

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_regif_pkg::*;
#(
  parameter int NCMP = 3,
  parameter int SW   = 3,
  parameter int DW   = 32
) (
  input  logic               rd_en,
  input  logic [SW-1:0]      acc_slot,
  input  logic [1:0]         acc_half,
  input  logic [31:0]        presc_q,
  input  logic [NCMP-1:0]    pend_q,
  input  logic [NCMP-1:0]    ien_q,
  input  logic [63:0]        time_q,
  input  logic [64*NCMP-1:0] cmp_q,
  output logic [DW-1:0]      hrdata
);

  logic [31:0] lo, hi;

  always_comb begin
    lo = '0;
    hi = '0;
    if (acc_slot == SW'(SLOT_PRESC)) begin
      lo = presc_q;
    end else if (acc_slot == SW'(SLOT_MASKS)) begin
      lo = 32'(pend_q);
      hi = 32'(ien_q);
    end else if (acc_slot == SW'(SLOT_TIME)) begin
      {hi, lo} = time_q;
    end
    for (int n = 0; n < NCMP; n++) begin
      if (acc_slot == SW'(SLOT_CMP0 + n)) {hi, lo} = cmp_q[64*n +: 64];
    end
  end

  if (DW == 64) begin : g_w64
    assign hrdata = rd_en ? {hi & {32{acc_half[1]}}, lo & {32{acc_half[0]}}} : '0;
  end else begin : g_w32
    assign hrdata = rd_en ? (acc_half[1] ? hi : lo) : '0;
  end

endmodule

// File: rtl/tmr_ahb_regif.sv
module tmr_ahb_regif
  import tmr_regif_pkg::*;
#(
  parameter int NCMP = 3,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic               hsel,
  input  logic [1:0]         htrans,
  input  logic [AW-1:0]      haddr,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic [DW-1:0]      hwdata,
  input  logic               hready,
  output logic [DW-1:0]      hrdata,
  output logic               hreadyout,
  output logic               hresp,
  input  logic [31:0]        presc_q,
  input  logic [NCMP-1:0]    pend_q,
  input  logic [NCMP-1:0]    ien_q,
  input  logic [63:0]        time_q,
  input  logic [64*NCMP-1:0] cmp_q,
  output logic [63:0]        wr_data,
  output logic               presc_we,
  output logic               ien_we,
  output logic [1:0]         time_we,
  output logic [2*NCMP-1:0]  cmp_we,
  output logic [NCMP-1:0]    pend_clr
);

  localparam int OFS_W = ofs_bits(NCMP);
  localparam int SW    = OFS_W - 3;

  logic          xfer_ok;
  logic          dbl;
  logic          acc_vld, acc_wr;
  logic [SW-1:0] acc_slot;
  logic [1:0]    acc_half;
  logic          unused_addr;

  assign hreadyout   = 1'b1;
  assign hresp       = 1'b0;
  assign xfer_ok     = hsel & hready & htrans[1];
  assign dbl         = (DW == 64) && (hsize == 3'b011);
  assign unused_addr = ^{haddr[AW-1:OFS_W], haddr[1:0]};

  // on a 32-bit bus both halves carry the same word
  assign wr_data = {hwdata[DW-1 -: 32], hwdata[31:0]};

  tmr_ahb_capture #(.SW(SW)) i_capture (
    .clk      (hclk),
    .rst_n    (hresetn),
    .xfer     (xfer_ok),
    .hwrite   (hwrite),
    .dbl      (dbl),
    .ofs      (haddr[OFS_W-1:2]),
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_slot (acc_slot),
    .acc_half (acc_half)
  );

  tmr_reg_decode #(.NCMP(NCMP), .SW(SW)) i_decode (
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_slot (acc_slot),
    .acc_half (acc_half),
    .presc_we (presc_we),
    .ien_we   (ien_we),
    .time_we  (time_we),
    .cmp_we   (cmp_we),
    .pend_clr (pend_clr)
  );

  tmr_rd_mux #(.NCMP(NCMP), .SW(SW), .DW(DW)) i_rd_mux (
    .rd_en    (acc_vld & ~acc_wr),
    .acc_slot (acc_slot),
    .acc_half (acc_half),
    .presc_q  (presc_q),
    .pend_q   (pend_q),
    .ien_q    (ien_q),
    .time_q   (time_q),
    .cmp_q    (cmp_q),
    .hrdata   (hrdata)
  );

  // ---------------- checks on the assembled slave ----------------
  logic [NCMP-1:0] cmp_any;
  logic            any_we;

  for (genvar n = 0; n < NCMP; n++) begin : g_chk
    assign cmp_any[n] = |cmp_we[2*n +: 2];

    AST_CMP_SLOT: assert property (@(posedge hclk) disable iff (!hresetn)
      cmp_any[n] |-> ($past(haddr[OFS_W-1:3]) == SW'(SLOT_CMP0 + n)));  // R4

    AST_CMP_CLEARS: assert property (@(posedge hclk) disable iff (!hresetn)
      $past(xfer_ok && hwrite && haddr[OFS_W-1:3] == SW'(SLOT_CMP0 + n))
        |-> pend_clr[n]);  // R8
  end

  assign any_we = presc_we | ien_we | (|time_we) | (|cmp_we);

  AST_WR_NEEDS_XFER: assert property (@(posedge hclk) disable iff (!hresetn)
    any_we |-> $past(xfer_ok && hwrite));  // R2

  AST_RD_ZERO_IDLE: assert property (@(posedge hclk) disable iff (!hresetn)
    !$past(xfer_ok && !hwrite) |-> (hrdata == '0));  // R10

  AST_ONE_REG: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0({presc_we, ien_we, |time_we, cmp_any}));  // R4

  if (DW == 32) begin : g_chk32
    AST_IEN_HIGH_ONLY: assert property (@(posedge hclk) disable iff (!hresetn)
      ien_we |-> $past(haddr[2]));  // R7

    AST_HALF_SINGLE: assert property (@(posedge hclk) disable iff (!hresetn)
      $countones({time_we, cmp_we}) <= 1);  // R5
  end

endmodule

// File: tb/test_tmr_ahb_regif.sv
`timescale 1ns/100ps
module test_tmr_ahb_regif;

  localparam int NCMP = 3;
  localparam int NV   = 22;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0, hready = 1'b1;
  logic [1:0]  htrans = 2'b00;
  logic [31:0] haddr = '0;
  logic [2:0]  hsize = 3'b010;
  logic [63:0] hwd = '0;

  logic [31:0]  presc_q = 32'hA5A5_0001;
  logic [2:0]   pend_q  = 3'b101;
  logic [2:0]   ien_q   = 3'b011;
  logic [63:0]  time_q  = 64'h1122_3344_5566_7788;
  logic [191:0] cmp_q   = {64'h2C2C2C2C_00000028, 64'h1B1B1B1B_00000020,
                           64'h0A0A0A0A_00000018};

  // 32-bit instance outputs
  logic [31:0] rd_a;  logic rdy_a, rsp_a;  logic [63:0] wd_a;
  logic pw_a, iw_a;   logic [1:0] tw_a;    logic [5:0] cw_a; logic [2:0] pc_a;
  // 64-bit instance outputs
  logic [63:0] rd_b;  logic rdy_b, rsp_b;  logic [63:0] wd_b;
  logic pw_b, iw_b;   logic [1:0] tw_b;    logic [5:0] cw_b; logic [2:0] pc_b;

  always #2.5 hclk = ~hclk;

  tmr_ahb_regif #(.NCMP(NCMP), .AW(32), .DW(32)) i_tmr_ahb_regif (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwd[31:0]), .hready(hready),
    .hrdata(rd_a), .hreadyout(rdy_a), .hresp(rsp_a),
    .presc_q(presc_q), .pend_q(pend_q), .ien_q(ien_q), .time_q(time_q), .cmp_q(cmp_q),
    .wr_data(wd_a), .presc_we(pw_a), .ien_we(iw_a), .time_we(tw_a), .cmp_we(cw_a),
    .pend_clr(pc_a));

  tmr_ahb_regif #(.NCMP(NCMP), .AW(32), .DW(64)) i_tmr_ahb_regif_w64 (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwd), .hready(hready),
    .hrdata(rd_b), .hreadyout(rdy_b), .hresp(rsp_b),
    .presc_q(presc_q), .pend_q(pend_q), .ien_q(ien_q), .time_q(time_q), .cmp_q(cmp_q),
    .wr_data(wd_b), .presc_we(pw_b), .ien_we(iw_b), .time_we(tw_b), .cmp_we(cw_b),
    .pend_clr(pc_b));

  // strobe vector: {presc, ien, time[1:0], cmp[5:0], clr[2:0]}
  wire [12:0] st_a = {pw_a, iw_a, tw_a, cw_a, pc_a};
  wire [12:0] st_b = {pw_b, iw_b, tw_b, cw_b, pc_b};

  int n_chk = 0, n_fail = 0;
  bit resp_bad = 1'b0;
  bit done = 1'b0;

  // {write, offset[11:0], wdata[31:0], expected[31:0]}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'hA5A50001},
    {1'b0, 12'h004, 32'h0, 32'h00000000},
    {1'b0, 12'h008, 32'h0, 32'h00000005},
    {1'b0, 12'h00C, 32'h0, 32'h00000003},
    {1'b0, 12'h010, 32'h0, 32'h55667788},
    {1'b0, 12'h014, 32'h0, 32'h11223344},
    {1'b0, 12'h018, 32'h0, 32'h00000018},
    {1'b0, 12'h01C, 32'h0, 32'h0A0A0A0A},
    {1'b0, 12'h024, 32'h0, 32'h1B1B1B1B},
    {1'b0, 12'h028, 32'h0, 32'h00000028},
    {1'b0, 12'h030, 32'h0, 32'h00000000},
    {1'b0, 12'h03C, 32'h0, 32'h00000000},
    {1'b1, 12'h000, 32'hDEAD0001, 32'h1000},
    {1'b1, 12'h008, 32'hDEAD0002, 32'h0000},
    {1'b1, 12'h00C, 32'hDEAD0003, 32'h0800},
    {1'b1, 12'h010, 32'hDEAD0004, 32'h0200},
    {1'b1, 12'h014, 32'hDEAD0005, 32'h0400},
    {1'b1, 12'h018, 32'hDEAD0006, 32'h0009},
    {1'b1, 12'h024, 32'hDEAD0007, 32'h0042},
    {1'b1, 12'h02C, 32'hDEAD0008, 32'h0104},
    {1'b1, 12'h034, 32'hDEAD0009, 32'h0000},
    {1'b1, 12'h004, 32'hDEAD000A, 32'h0000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // address phase, then data phase; returns sampling in mid data phase
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [2:0] sz,
                      input logic [1:0] tr, input logic sel, input logic rdy,
                      input logic [63:0] wdat);
    @(negedge hclk);
    hsel = sel; htrans = tr; haddr = a; hwrite = wr; hsize = sz; hready = rdy;
    @(posedge hclk);
    #1;
    hsel = 1'b0; htrans = 2'b00; hready = 1'b1; hwd = wdat;
    @(negedge hclk);
  endtask

  always @(negedge hclk)
    if (rdy_a !== 1'b1 || rsp_a !== 1'b0 || rdy_b !== 1'b1 || rsp_b !== 1'b0)
      resp_bad = 1'b1;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    #7;
    check("R1 readyout in reset", {63'd0, rdy_a}, 64'd1);
    check("R10 strobes in reset", {51'd0, st_a}, 64'd0);
    @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);
    check("R10 rdata after reset", {32'd0, rd_a}, 64'd0);
    check("R10 strobes after reset", {51'd0, st_b}, 64'd0);

    // vector table on the 32-bit bus
    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [11:0] o;
      logic [31:0] d, e;
      {w, o, d, e} = VEC[i];
      xfer(w, {20'd0, o}, 3'b010, 2'b10, 1'b1, 1'b1, {32'h0, d});
      if (w) begin
        check($sformatf("R4 R5 R7 R8 R9 write strobes vec %0d", i), {51'd0, st_a}, {32'd0, e});
        check($sformatf("R3 R5 wr_data vec %0d", i), wd_a, {d, d});
        check($sformatf("R10 no rdata on write vec %0d", i), {32'd0, rd_a}, 64'd0);
      end else begin
        check($sformatf("R4 R5 R9 read vec %0d", i), {32'd0, rd_a}, {32'd0, e});
        check($sformatf("R3 no strobe on read vec %0d", i), {51'd0, st_a}, 64'd0);
      end
    end

    // R3: outputs fall back one cycle after a single transfer
    xfer(1'b1, 32'h10, 3'b010, 2'b10, 1'b1, 1'b1, 64'h0000_0000_1234_5678);
    check("R3 strobe in data phase", {51'd0, st_a}, 64'h0200);
    @(negedge hclk);
    check("R3 strobe drops next cycle", {51'd0, st_a}, 64'd0);
    xfer(1'b0, 32'h0, 3'b010, 2'b10, 1'b1, 1'b1, 64'd0);
    @(negedge hclk);
    check("R3 R10 rdata drops next cycle", {32'd0, rd_a}, 64'd0);

    // R2: rejected transfers
    xfer(1'b1, 32'h0, 3'b010, 2'b10, 1'b0, 1'b1, 64'h1);
    check("R2 hsel low ignored", {51'd0, st_a}, 64'd0);
    xfer(1'b1, 32'h0, 3'b010, 2'b01, 1'b1, 1'b1, 64'h1);
    check("R2 busy ignored", {51'd0, st_a}, 64'd0);
    xfer(1'b1, 32'h0, 3'b010, 2'b00, 1'b1, 1'b1, 64'h1);
    check("R2 idle ignored", {51'd0, st_a}, 64'd0);
    xfer(1'b1, 32'h0, 3'b010, 2'b10, 1'b1, 1'b0, 64'h1);
    check("R2 hready low ignored", {51'd0, st_a}, 64'd0);
    xfer(1'b0, 32'h0, 3'b010, 2'b10, 1'b0, 1'b1, 64'h0);
    check("R2 unselected read gives zero", {32'd0, rd_a}, 64'd0);
    xfer(1'b1, 32'h0C, 3'b010, 2'b11, 1'b1, 1'b1, 64'h7);
    check("R2 seq accepted", {51'd0, st_a}, 64'h0800);

    // R6: 64-bit bus
    xfer(1'b0, 32'h10, 3'b011, 2'b10, 1'b1, 1'b1, 64'd0);
    check("R6 dword time read", rd_b, 64'h1122_3344_5566_7788);
    xfer(1'b0, 32'h08, 3'b011, 2'b10, 1'b1, 1'b1, 64'd0);
    check("R6 R9 dword masks read", rd_b, 64'h0000_0003_0000_0005);
    xfer(1'b0, 32'h14, 3'b010, 2'b10, 1'b1, 1'b1, 64'd0);
    check("R6 word read high lane", rd_b, 64'h1122_3344_0000_0000);
    xfer(1'b1, 32'h18, 3'b011, 2'b10, 1'b1, 1'b1, 64'h1111_2222_3333_4444);
    check("R6 R8 dword cmp write", {51'd0, st_b}, 64'h0019);
    check("R6 dword wr_data", wd_b, 64'h1111_2222_3333_4444);
    xfer(1'b1, 32'h0C, 3'b010, 2'b10, 1'b1, 1'b1, 64'hABCD_0000_0000_0000);
    check("R6 word write high lane", {51'd0, st_b}, 64'h0800);
    check("R6 high lane data", {32'd0, wd_b[63:32]}, 64'hABCD_0000);
    xfer(1'b1, 32'h08, 3'b011, 2'b10, 1'b1, 1'b1, 64'h5);
    check("R7 dword mask write hits only enable", {51'd0, st_b}, 64'h0800);

    @(negedge hclk);
    check("R1 ready and okay all run", {63'd0, resp_bad}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule